// File: doc/BRIEF.md
# Lock-Status Change Interrupt Reporter

This block monitors a pair of lock-limit comparator lines. One line asks for an increase and the other asks for a decrease. Whenever either line moves, the block takes a snapshot of both into an 8-bit status register. If interrupts are enabled, it also pulls an active-low request line to the host processor. The host reads the snapshot one bit at a time. It does this by strobing a shift clock while it holds its acknowledge low, and that same acknowledge clears the request. An output-side clock can also drive the register, gated by a separate load-gate level.

All inputs are asynchronous and are brought into the block clock domain by multi-flop synchronizers. The two shift clocks are never used as clocks. Their rising edges are turned into one-cycle shift enables.

A rising edge on a force input raises the request directly. Any change on the enable input takes a fresh snapshot without raising a request, so the host can poll the lock lines whenever it wants. Data on the serial input is shifted into the register's low end. A pattern written in by the host therefore comes back out eight shifts later, which gives a loopback test of the serial link.

Top module: `lock_irq_reporter`

## Requirements
- R1: A snapshot loads the register (bit 7 is the MSB) with the decrease line in bit 7, the increase line in bit 6, a constant 1 in bit 4 and 0 in bits 5, 3, 2, 1 and 0. The MSB is presented on ser_out first.
- R2: Any rising or falling change on lock_inc or lock_dec, including both at once, reloads the register with the current line levels. The new bit 7 appears on ser_out three clock edges after the input change.
- R3: A lock-line change seen while irq_enable is high sets the interrupt flag, and irq_n goes low three clock edges after the change. A change seen while irq_enable is low leaves irq_n high.
- R4: Any change on irq_enable reloads the register but does not set the interrupt flag.
- R5: A rising edge on force_irq sets the interrupt flag whatever the lock lines do. The flag stays set after force_irq returns low.
- R6: While ack_n is low, the interrupt flag is cleared and irq_n returns high.
- R7: While ack_n is low, each rising edge of host_sclk shifts the register by one position toward the MSB. host_sclk has no effect while ack_n is high.
- R8: While readback_gate is high, each rising edge of out_sclk shifts the register by one position. out_sclk has no effect while readback_gate is low.
- R9: On each shift, the synchronized level of ser_in enters bit 0. A byte shifted in MSB first therefore emerges unchanged on ser_out over the next eight shifts.
- R10: If a snapshot and a shift fall in the same cycle, the snapshot wins and no shift happens.
- R11: If a set and a clear of the interrupt flag fall in the same cycle, the flag is set. It is cleared on the following cycle if ack_n is still low.
- R12: Synchronous reset clears the register and the flag. The edge history is seeded from the current input levels, so input levels held steady through reset cause no snapshot and no interrupt afterward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| lock_inc | input | 1 | Increase-request lock-limit line (asynchronous) |
| lock_dec | input | 1 | Decrease-request lock-limit line (asynchronous) |
| irq_enable | input | 1 | Interrupt enable level; any change also takes a snapshot |
| force_irq | input | 1 | Rising edge forces the interrupt flag set |
| ack_n | input | 1 | Host acknowledge, active low: clears the flag and gates host_sclk |
| readback_gate | input | 1 | High level gates out_sclk onto the shift register |
| host_sclk | input | 1 | Host-side shift clock, sampled as a shift enable |
| out_sclk | input | 1 | Output-side shift clock, sampled as a shift enable |
| ser_in | input | 1 | Serial data shifted into bit 0 |
| ser_out | output | 1 | Serial data from the register MSB |
| irq_n | output | 1 | Interrupt request to the host, active low |

## Verification
A wrong bit in the status register shows up as a wrong level on ser_out at the shift that brings that bit to the MSB, which is at most eight shifts after the snapshot. A register that loaded or shifted when it should not have shows up on ser_out three clock edges after the input that caused it. A stuck or wrongly cleared interrupt flag shows up on irq_n three clock edges after the lock-line change, force edge or acknowledge that should have moved it. In a collision of set and clear, the flag is visible for exactly one cycle before the acknowledge takes it down, so that is the cycle to sample.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
   // Lane numbering of the synchronized input vector. The lanes that feed
   // the any-change detector and the rising-edge detector must be contiguous.
   localparam int LN_INC   = 0;
   localparam int LN_DEC   = 1;
   localparam int LN_EN    = 2;
   localparam int LN_FORCE = 3;
   localparam int LN_HCLK  = 4;
   localparam int LN_OCLK  = 5;
   localparam int LN_ACK   = 6;
   localparam int LN_GATE  = 7;
   localparam int LN_SIN   = 8;
   localparam int LN_COUNT = 9;
endpackage

// File: rtl/lsr_sync.sv
module lsr_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] lvl
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lsr_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("lsr_sync: WIDTH must be at least 1");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < WIDTH; gi++) begin : g_lane
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (rst) begin
               chain <= {STAGES{din[gi]}};
            end else begin
               chain <= {chain[STAGES-2:0], din[gi]};
            end
         end
         assign lvl[gi] = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/lsr_edge.sv
module lsr_edge #(
   parameter int WIDTH     = 1,
   parameter bit RISE_ONLY = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] seed,
   input  logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] ev
);
   logic [WIDTH-1:0] hist;

   always_ff @(posedge clk) begin
      if (rst) begin
         hist <= seed;
      end else begin
         hist <= lvl;
      end
   end

   generate
      if (RISE_ONLY) begin : g_rise
         assign ev = lvl & ~hist;
      end else begin : g_any
         assign ev = lvl ^ hist;
      end
   endgenerate
endmodule

// File: rtl/lsr_capture_shift.sv
module lsr_capture_shift #(
   parameter int WIDTH     = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [WIDTH-1:0] pvec,
   input  logic             shift,
   input  logic             sin,
   output logic             sout
);
   logic [WIDTH-1:0] q_r;
   logic [WIDTH-1:0] shifted;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("lsr_capture_shift: WIDTH must be at least 2");
      end
      if (MSB_FIRST) begin : g_msb
         assign shifted = {q_r[WIDTH-2:0], sin};
         assign sout    = q_r[WIDTH-1];
         AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (rst)
            (shift && !load) |=> (q_r[WIDTH-1:1] == $past(q_r[WIDTH-2:0]) && q_r[0] == $past(sin))); // R9
      end else begin : g_lsb
         assign shifted = {sin, q_r[WIDTH-1:1]};
         assign sout    = q_r[0];
         AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (rst)
            (shift && !load) |=> (q_r[WIDTH-2:0] == $past(q_r[WIDTH-1:1]) && q_r[WIDTH-1] == $past(sin))); // R9
      end
   endgenerate

   // A snapshot takes priority over a shift in the same cycle.
   always_ff @(posedge clk) begin
      if (rst) begin
         q_r <= '0;
      end else if (load) begin
         q_r <= pvec;
      end else if (shift) begin
         q_r <= shifted;
      end
   end

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
      load |=> (q_r == $past(pvec))); // R10
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!load && !shift) |=> $stable(q_r)); // R7
   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (q_r == '0)); // R12
endmodule

// File: rtl/lsr_irq_flag.sv
module lsr_irq_flag (
   input  logic clk,
   input  logic rst,
   input  logic set_req,
   input  logic clr_req,
   output logic flag
);
   // A set outranks a clear so that no lock event is lost.
   always_ff @(posedge clk) begin
      if (rst) begin
         flag <= 1'b0;
      end else if (set_req) begin
         flag <= 1'b1;
      end else if (clr_req) begin
         flag <= 1'b0;
      end
   end

   AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      set_req |=> flag); // R11
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (!set_req && clr_req) |=> !flag); // R6
   AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!set_req && !clr_req) |=> $stable(flag)); // R5
endmodule

// File: rtl/lock_irq_reporter.sv
module lock_irq_reporter
   import lsr_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int STAT_W      = 8,
   parameter int DEC_BIT     = 7,
   parameter int INC_BIT     = 6,
   parameter int ID_BIT      = 4,
   parameter bit MSB_FIRST   = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic lock_inc,
   input  logic lock_dec,
   input  logic irq_enable,
   input  logic force_irq,
   input  logic ack_n,
   input  logic readback_gate,
   input  logic host_sclk,
   input  logic out_sclk,
   input  logic ser_in,
   output logic ser_out,
   output logic irq_n
);
   localparam int NLANE  = LN_COUNT;
   localparam int NCHG   = LN_EN - LN_INC + 1;
   localparam int NRISE  = LN_OCLK - LN_FORCE + 1;

   generate
      if (STAT_W < 3) begin : g_bad_w
         $error("lock_irq_reporter: STAT_W must be at least 3");
      end
      if (DEC_BIT >= STAT_W || INC_BIT >= STAT_W || ID_BIT >= STAT_W) begin : g_bad_pos
         $error("lock_irq_reporter: field position outside the status register");
      end
      if (DEC_BIT == INC_BIT || DEC_BIT == ID_BIT || INC_BIT == ID_BIT) begin : g_dup_pos
         $error("lock_irq_reporter: field positions must be distinct");
      end
   endgenerate

   logic [NLANE-1:0] raw;
   logic [NLANE-1:0] lvl;
   logic [NCHG-1:0]  chg;
   logic [NRISE-1:0] rise;

   assign raw[LN_INC]   = lock_inc;
   assign raw[LN_DEC]   = lock_dec;
   assign raw[LN_EN]    = irq_enable;
   assign raw[LN_FORCE] = force_irq;
   assign raw[LN_HCLK]  = host_sclk;
   assign raw[LN_OCLK]  = out_sclk;
   assign raw[LN_ACK]   = ack_n;
   assign raw[LN_GATE]  = readback_gate;
   assign raw[LN_SIN]   = ser_in;

   lsr_sync #(.WIDTH(NLANE), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .din (raw),
      .lvl (lvl)
   );

   lsr_edge #(.WIDTH(NCHG), .RISE_ONLY(1'b0)) u_chg (
      .clk  (clk),
      .rst  (rst),
      .seed (raw[LN_EN:LN_INC]),
      .lvl  (lvl[LN_EN:LN_INC]),
      .ev   (chg)
   );

   lsr_edge #(.WIDTH(NRISE), .RISE_ONLY(1'b1)) u_rise (
      .clk  (clk),
      .rst  (rst),
      .seed (raw[LN_OCLK:LN_FORCE]),
      .lvl  (lvl[LN_OCLK:LN_FORCE]),
      .ev   (rise)
   );

   logic lock_chg, en_chg, snap, irq_set, irq_clr, shift_en, irq_flag;
   logic [STAT_W-1:0] pvec;

   assign lock_chg = chg[LN_INC - LN_INC] | chg[LN_DEC - LN_INC];
   assign en_chg   = chg[LN_EN - LN_INC];
   assign snap     = lock_chg | en_chg;
   assign irq_set  = (lock_chg & lvl[LN_EN]) | rise[LN_FORCE - LN_FORCE];
   assign irq_clr  = ~lvl[LN_ACK];
   assign shift_en = (rise[LN_HCLK - LN_FORCE] & ~lvl[LN_ACK])
                   | (rise[LN_OCLK - LN_FORCE] & lvl[LN_GATE]);

   always_comb begin
      pvec          = '0;
      pvec[DEC_BIT] = lvl[LN_DEC];
      pvec[INC_BIT] = lvl[LN_INC];
      pvec[ID_BIT]  = 1'b1;
   end

   lsr_capture_shift #(.WIDTH(STAT_W), .MSB_FIRST(MSB_FIRST)) u_reg (
      .clk   (clk),
      .rst   (rst),
      .load  (snap),
      .pvec  (pvec),
      .shift (shift_en),
      .sin   (lvl[LN_SIN]),
      .sout  (ser_out)
   );

   lsr_irq_flag u_flag (
      .clk     (clk),
      .rst     (rst),
      .set_req (irq_set),
      .clr_req (irq_clr),
      .flag    (irq_flag)
   );

   assign irq_n = ~irq_flag;

   AST_IRQ_ON_LOCK: assert property (@(posedge clk) disable iff (rst)
      (lock_chg && lvl[LN_EN]) |=> !irq_n); // R3
   AST_EN_EDGE_QUIET: assert property (@(posedge clk) disable iff (rst)
      (en_chg && !lock_chg && !rise[LN_FORCE - LN_FORCE] && irq_n) |=> irq_n); // R4
   AST_RESET_IDLE: assert property (@(posedge clk)
      rst |=> irq_n); // R12
endmodule

// File: tb/lock_irq_reporter_bench.sv
module lock_irq_reporter_bench;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic lock_inc = 1'b1, lock_dec = 1'b1, irq_enable = 1'b0, force_irq = 1'b0;
   logic ack_n = 1'b1, readback_gate = 1'b0, host_sclk = 1'b0, out_sclk = 1'b0;
   logic ser_in = 1'b0;
   logic ser_out, irq_n;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   lock_irq_reporter u_lock_irq_reporter (
      .clk(clk), .rst(rst), .lock_inc(lock_inc), .lock_dec(lock_dec),
      .irq_enable(irq_enable), .force_irq(force_irq), .ack_n(ack_n),
      .readback_gate(readback_gate), .host_sclk(host_sclk), .out_sclk(out_sclk),
      .ser_in(ser_in), .ser_out(ser_out), .irq_n(irq_n)
   );

   // Stimulus vectors {lock_inc, lock_dec, irq_enable}.
   localparam logic [2:0] VEC [0:5] = '{3'b100, 3'b101, 3'b011, 3'b111, 3'b110, 3'b000};
   localparam logic [7:0] FILL = 8'hA6;

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input bit via_out, input logic d);
      ser_in = d;
      if (via_out) out_sclk = 1'b1; else host_sclk = 1'b1;
      idle(4);
      if (via_out) out_sclk = 1'b0; else host_sclk = 1'b0;
      idle(4);
   endtask

   task automatic read_reg(input bit via_out, input logic [7:0] exp,
                           input logic [7:0] fill, input string req);
      if (via_out) readback_gate = 1'b1; else ack_n = 1'b0;
      idle(4);
      for (int k = 0; k < 8; k++) begin
         chk(req, ser_out, exp[7-k]);
         pulse(via_out, fill[7-k]);
      end
      chk("R9", ser_out, fill[7]);
      readback_gate = 1'b0;
      ack_n = 1'b1;
      ser_in = 1'b0;
      idle(4);
   endtask

   initial begin
      logic [2:0] prev;
      prev = 3'b110;
      idle(5);
      rst = 1'b0;
      idle(8);
      // R12: cleared register, quiet request, no false snapshot from held levels
      chk("R12", ser_out, 1'b0);
      chk("R12", irq_n, 1'b1);

      for (int i = 0; i < 6; i++) begin
         logic [2:0] v;
         logic       moved;
         logic [7:0] exp_reg;
         string      lbl;
         v = VEC[i];
         moved = (v[2] != prev[2]) || (v[1] != prev[1]);
         exp_reg = {v[1], v[2], 1'b0, 1'b1, 4'b0000};
         lbl = (!moved) ? "R4" : ((i == 0) ? "R1" : "R2");
         lock_inc = v[2];
         lock_dec = v[1];
         irq_enable = v[0];
         idle(4);
         chk(moved ? "R3" : "R4", irq_n, !(moved && v[0]));
         read_reg(1'b0, exp_reg, FILL, lbl);
         chk("R6", irq_n, 1'b1);
         prev = v;
      end

      // R7: host clock ignored while acknowledge is high
      pulse(1'b0, 1'b0);
      chk("R7", ser_out, FILL[7]);
      // R8: output clock ignored while gate is low
      pulse(1'b1, 1'b0);
      chk("R8", ser_out, FILL[7]);
      // R8/R9: loopback pattern read back over the gated output clock
      read_reg(1'b1, FILL, 8'h00, "R8");

      // R5: force edge sets the flag, which holds after the input falls
      force_irq = 1'b1;
      idle(4);
      chk("R5", irq_n, 1'b0);
      force_irq = 1'b0;
      idle(4);
      chk("R5", irq_n, 1'b0);
      ack_n = 1'b0;
      idle(4);
      chk("R6", irq_n, 1'b1);

      // R10: snapshot and shift together; snapshot wins (old bit 6 was 0)
      lock_dec = 1'b1;
      host_sclk = 1'b1;
      idle(4);
      chk("R10", ser_out, 1'b1);
      host_sclk = 1'b0;
      idle(4);

      // R11: set and clear collide; flag visible for exactly one cycle
      irq_enable = 1'b1;
      idle(6);
      lock_inc = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      chk("R11", irq_n, 1'b0);
      @(posedge clk);
      #1;
      chk("R11", irq_n, 1'b1);
      @(negedge clk);
      ack_n = 1'b1;
      idle(4);

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule